// File: doc/BRIEF.md
# Automatic Serial Flow Controller

This block throttles a serial link in both directions without software help. It watches the fill level of the receive queue. When the level climbs to an upper mark, it asks the far end to stop. It does this by queuing an Xoff control character for the serializer and by raising the active-low request lines. When the level drains to a lower mark, it queues Xon and lowers those lines again. The two character values and the two marks are configuration inputs.

In the other direction, the block decides whether the transmit queue may release its next character. A received Xoff pauses the transmitter and a received Xon resumes it. Those two characters are removed from the receive stream so that they never reach the receive queue. An inactive clear/ready modem input also holds the transmitter. That input is resynchronized first, and it only takes effect between characters. The character-based and line-based schemes can be enabled separately or together, and the whole flow state is visible on a status vector.

Character serialization is outside this block. A serializer next to it reports whether it is busy, takes control characters through a request/acknowledge pair, and pulls data characters only while `tx_go` is high.

Top module: `sflow_ctrl`

## Requirements
- R1: After reset, `fc_status` is 0, `ins_req` is 0 and `rts_n`/`dtr_n` are 0. `tx_go` equals `tx_q_nempty & ~tx_busy & ~cfg_tx_dis & ~ins_req & ~paused`, where paused means either status bit 1 or status bit 2 is set.
- R2: When not throttled and `rx_level >= cfg_hi_thr`, status bit 0 becomes 1 on the next clock edge. With `cfg_ib_en`=1, exactly one Xoff insertion (`ins_chr == cfg_xoff`) is then requested, and it is held until acknowledged.
- R3: When throttled and `rx_level <= cfg_lo_thr`, status bit 0 clears on the next edge and exactly one Xon insertion is requested. Levels strictly between the marks change nothing.
- R4: A control character takes priority over data: while `ins_req` is 1, `tx_go` is 0. `ins_req` only rises while `tx_busy` is 0, and `ins_ack` in a cycle with `ins_req` high retires the request.
- R5: With `cfg_ib_en`=1, a received strobe carrying `cfg_xoff` sets status bit 1 on the next edge, which forces `tx_go` low. A later `cfg_xon` clears the bit. Other characters leave it unchanged.
- R6: While `cfg_ib_en`=1, received Xon/Xoff characters are consumed (`rx_wr` stays 0 in their strobe cycle). All other received characters give `rx_wr`=1 in their strobe cycle.
- R7: `cfg_oob_mode` bit 0 enables the RTS/CTS pair and bit 1 the DTR/DSR pair. An enabled output line is 1 (deasserted) exactly while throttled. A disabled output line stays 0.
- R8: An enabled input line (`cts_n` for bit 0, `dsr_n` for bit 1) at 1 sets status bit 2 on the third clock edge after the change. The bit is only updated on edges where `tx_busy` is 0. Inputs of disabled pairs are ignored.
- R9: `cfg_tx_dis`=1 holds both `tx_go` and `ins_req` at 0, but a pending request is kept. `cfg_rx_dis`=1 holds `rx_wr` at 0 and makes received Xon/Xoff have no effect.
- R10: `fc_status` layout: bit 0 receive throttled, bit 1 paused by received Xoff, bit 2 paused by modem input, bit 3 control character pending.
- R11: With `cfg_ib_en`=0, no insertion is requested and status bit 1 is 0. Xon/Xoff values are written like data (`rx_wr`=1), while threshold crossings still drive the enabled modem lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ib_en | input | 1 | Enable character-based flow control |
| cfg_oob_mode | input | 2 | Bit 0: RTS/CTS pair, bit 1: DTR/DSR pair |
| cfg_hi_thr | input | LVL_W | Upper receive mark (throttle) |
| cfg_lo_thr | input | LVL_W | Lower receive mark (release) |
| cfg_xon | input | DATA_W | Resume character value |
| cfg_xoff | input | DATA_W | Pause character value |
| cfg_tx_dis | input | 1 | Disable transmitter |
| cfg_rx_dis | input | 1 | Disable receiver |
| rx_level | input | LVL_W | Current receive queue level |
| rx_char_vld | input | 1 | Received character strobe |
| rx_char | input | DATA_W | Received character |
| rx_wr | output | 1 | Write the strobed character into the receive queue |
| tx_q_nempty | input | 1 | Transmit queue holds data |
| tx_busy | input | 1 | Serializer is shifting a character |
| tx_go | output | 1 | Serializer may take the next data character |
| ins_req | output | 1 | Request to send a control character |
| ins_chr | output | DATA_W | Control character to send |
| ins_ack | input | 1 | Serializer accepted the control character |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| fc_status | output | 4 | Flow state, layout per R10 |

## Verification
The bench builds the block with DATA_W=8, LVL_W=8 and SYNC_STAGES=2. An 8-bit level reaches far beyond both marks (100 and 20), so it can cover the equal-to-mark crossings, the dead band between the marks and a fully drained queue. The two-stage synchronizer keeps the modem-input latency at three edges, so the bench can check the input was ignored for two edges and taken on the third. With that short latency it can also hold `tx_busy` high for a longer stretch and show the pause waits for the character boundary.

// File: rtl/sflow_pkg.sv
`timescale 1ns/1ps
package sflow_pkg;
   // modem pair selection bits
   localparam int OOB_RTS_BIT = 0;
   localparam int OOB_DTR_BIT = 1;

   // status vector layout
   localparam int ST_THROTTLED = 0;
   localparam int ST_RMT_PAUSE = 1;
   localparam int ST_LINE_HOLD = 2;
   localparam int ST_CTL_PEND  = 3;
   localparam int ST_W         = 4;

   typedef enum logic [1:0] {
      CTL_NONE = 2'b00,
      CTL_XON  = 2'b01,
      CTL_XOFF = 2'b10
   } ctl_kind_e;
endpackage

// File: rtl/sflow_sync.sv
`timescale 1ns/1ps
module sflow_sync #(
   parameter int   N_LINES = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] din,
   output logic [N_LINES-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sflow_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_LVL}};
            else        sh <= {sh[STAGES-2:0], din[i]};
         end
         assign dout[i] = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sflow_rxthr.sv
`timescale 1ns/1ps
module sflow_rxthr #(
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] hi_thr,
   input  logic [LVL_W-1:0] lo_thr,
   output logic             throttled,
   output logic             set_evt,
   output logic             clr_evt
);
   logic at_hi, at_lo;

   assign at_hi   = (rx_level >= hi_thr);
   assign at_lo   = (rx_level <= lo_thr);
   assign set_evt = !throttled && at_hi;
   assign clr_evt =  throttled && at_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       throttled <= 1'b0;
      else if (set_evt) throttled <= 1'b1;
      else if (clr_evt) throttled <= 1'b0;
   end

   // R2
   throttle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(throttled) |-> ($past(rx_level) >= $past(hi_thr)));

   // R3
   release_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(throttled) |-> ($past(rx_level) <= $past(lo_thr)));
endmodule

// File: rtl/sflow_ibctl.sv
`timescale 1ns/1ps
module sflow_ibctl
   import sflow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ib_en,
   input  logic              tx_dis,
   input  logic              rx_dis,
   input  logic              tx_busy,
   input  logic [DATA_W-1:0] xon_chr,
   input  logic [DATA_W-1:0] xoff_chr,
   input  logic              rx_vld,
   input  logic [DATA_W-1:0] rx_chr,
   input  logic              set_evt,
   input  logic              clr_evt,
   input  logic              ins_ack,
   output logic              ins_req,
   output logic [DATA_W-1:0] ins_chr,
   output logic              rmt_paused,
   output logic              ctl_hit,
   output logic              pend
);
   ctl_kind_e pend_kind;
   logic      hit_on, hit_off, seen;

   assign seen    = rx_vld && !rx_dis && ib_en;
   assign hit_off = seen && (rx_chr == xoff_chr);
   assign hit_on  = seen && (rx_chr == xon_chr) && !hit_off;
   assign ctl_hit = hit_on || hit_off;

   // remote pause state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rmt_paused <= 1'b0;
      else if (!ib_en)  rmt_paused <= 1'b0;
      else if (hit_off) rmt_paused <= 1'b1;
      else if (hit_on)  rmt_paused <= 1'b0;
   end

   // pending control character: newest crossing replaces an unsent one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend_kind <= CTL_NONE;
      else if (!ib_en)            pend_kind <= CTL_NONE;
      else if (set_evt)           pend_kind <= CTL_XOFF;
      else if (clr_evt)           pend_kind <= CTL_XON;
      else if (ins_req && ins_ack) pend_kind <= CTL_NONE;
   end

   assign pend    = (pend_kind != CTL_NONE);
   assign ins_req = pend && !tx_dis && !tx_busy;
   assign ins_chr = (pend_kind == CTL_XOFF) ? xoff_chr : xon_chr;

   // R2
   xoff_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && ib_en) |=> (pend && ins_chr == xoff_chr));

   // R3
   xon_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && ib_en) |=> (pend && ins_chr == xon_chr));

   // R4
   req_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_req |-> !tx_busy);

   // R11
   no_ib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ib_en |=> (!rmt_paused && !ins_req));
endmodule

// File: rtl/sflow_oob.sv
`timescale 1ns/1ps
module sflow_oob
   import sflow_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       throttled,
   input  logic       tx_busy,
   input  logic       cts_n,
   input  logic       dsr_n,
   output logic       rts_n,
   output logic       dtr_n,
   output logic       line_hold
);
   logic [1:0] raw_in, sync_in, stop_req;

   assign raw_in[OOB_RTS_BIT] = cts_n;
   assign raw_in[OOB_DTR_BIT] = dsr_n;

   sflow_sync #(.N_LINES(2), .STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (sync_in)
   );

   generate
      for (genvar p = 0; p < 2; p++) begin : g_pair
         assign stop_req[p] = mode[p] && sync_in[p];
      end
   endgenerate

   // sampled only between characters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        line_hold <= 1'b0;
      else if (!tx_busy) line_hold <= |stop_req;
   end

   assign rts_n = mode[OOB_RTS_BIT] && throttled;
   assign dtr_n = mode[OOB_DTR_BIT] && throttled;

   // R8
   hold_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(line_hold));

   // R7
   line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !throttled |-> (!rts_n && !dtr_n));
endmodule

// File: rtl/sflow_ctrl.sv
`timescale 1ns/1ps
module sflow_ctrl
   import sflow_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LVL_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ib_en,
   input  logic [1:0]        cfg_oob_mode,
   input  logic [LVL_W-1:0]  cfg_hi_thr,
   input  logic [LVL_W-1:0]  cfg_lo_thr,
   input  logic [DATA_W-1:0] cfg_xon,
   input  logic [DATA_W-1:0] cfg_xoff,
   input  logic              cfg_tx_dis,
   input  logic              cfg_rx_dis,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_char_vld,
   input  logic [DATA_W-1:0] rx_char,
   output logic              rx_wr,
   input  logic              tx_q_nempty,
   input  logic              tx_busy,
   output logic              tx_go,
   output logic              ins_req,
   output logic [DATA_W-1:0] ins_chr,
   input  logic              ins_ack,
   input  logic              cts_n,
   input  logic              dsr_n,
   output logic              rts_n,
   output logic              dtr_n,
   output logic [ST_W-1:0]   fc_status
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data_w
         $error("sflow_ctrl: DATA_W must be 5 to 9");
      end
      if (LVL_W < 2) begin : g_bad_lvl_w
         $error("sflow_ctrl: LVL_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sflow_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic throttled, set_evt, clr_evt;
   logic rmt_paused, ctl_hit, pend, line_hold;

   sflow_rxthr #(.LVL_W(LVL_W)) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_level (rx_level),
      .hi_thr   (cfg_hi_thr),
      .lo_thr   (cfg_lo_thr),
      .throttled(throttled),
      .set_evt  (set_evt),
      .clr_evt  (clr_evt)
   );

   sflow_ibctl #(.DATA_W(DATA_W)) u_ib (
      .clk       (clk),
      .rst_n     (rst_n),
      .ib_en     (cfg_ib_en),
      .tx_dis    (cfg_tx_dis),
      .rx_dis    (cfg_rx_dis),
      .tx_busy   (tx_busy),
      .xon_chr   (cfg_xon),
      .xoff_chr  (cfg_xoff),
      .rx_vld    (rx_char_vld),
      .rx_chr    (rx_char),
      .set_evt   (set_evt),
      .clr_evt   (clr_evt),
      .ins_ack   (ins_ack),
      .ins_req   (ins_req),
      .ins_chr   (ins_chr),
      .rmt_paused(rmt_paused),
      .ctl_hit   (ctl_hit),
      .pend      (pend)
   );

   sflow_oob #(.SYNC_STAGES(SYNC_STAGES)) u_oob (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (cfg_oob_mode),
      .throttled(throttled),
      .tx_busy  (tx_busy),
      .cts_n    (cts_n),
      .dsr_n    (dsr_n),
      .rts_n    (rts_n),
      .dtr_n    (dtr_n),
      .line_hold(line_hold)
   );

   assign rx_wr = rx_char_vld && !cfg_rx_dis && !ctl_hit;
   assign tx_go = tx_q_nempty && !tx_busy && !cfg_tx_dis && !ins_req
                  && !rmt_paused && !line_hold;

   always_comb begin
      fc_status               = '0;
      fc_status[ST_THROTTLED] = throttled;
      fc_status[ST_RMT_PAUSE] = rmt_paused;
      fc_status[ST_LINE_HOLD] = line_hold;
      fc_status[ST_CTL_PEND]  = pend;
   end

   // R4
   go_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_req |-> !tx_go);

   // R9
   tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tx_dis |-> (!tx_go && !ins_req));

   // R5
   remote_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fc_status[ST_RMT_PAUSE] |-> !tx_go);

   // R6
   ctl_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ib_en && rx_char_vld && (rx_char == cfg_xoff)) |-> !rx_wr);
endmodule

// File: tb/sim_sflow_ctrl.sv
`timescale 1ns/1ps
module sim_sflow_ctrl;
   localparam int DW = 8;
   localparam int LW = 8;
   localparam logic [DW-1:0] XON  = 8'h11;
   localparam logic [DW-1:0] XOFF = 8'h13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_ib_en, cfg_tx_dis, cfg_rx_dis;
   logic [1:0]    cfg_oob_mode;
   logic [LW-1:0] cfg_hi_thr, cfg_lo_thr, rx_level;
   logic [DW-1:0] cfg_xon, cfg_xoff, rx_char, ins_chr;
   logic          rx_char_vld, rx_wr, tx_q_nempty, tx_busy, tx_go;
   logic          ins_req, ins_ack, cts_n, dsr_n, rts_n, dtr_n;
   logic [3:0]    fc_status;

   int total = 0;
   int bad   = 0;
   int ins_seen = 0;
   bit done = 0;
   logic [DW-1:0] exp_q[$];

   always #2 clk = ~clk;

   sflow_ctrl #(.DATA_W(DW), .LVL_W(LW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ib_en(cfg_ib_en), .cfg_oob_mode(cfg_oob_mode),
      .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_xon(cfg_xon),
      .cfg_xoff(cfg_xoff), .cfg_tx_dis(cfg_tx_dis), .cfg_rx_dis(cfg_rx_dis),
      .rx_level(rx_level), .rx_char_vld(rx_char_vld), .rx_char(rx_char),
      .rx_wr(rx_wr), .tx_q_nempty(tx_q_nempty), .tx_busy(tx_busy), .tx_go(tx_go),
      .ins_req(ins_req), .ins_chr(ins_chr), .ins_ack(ins_ack), .cts_n(cts_n),
      .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n), .fc_status(fc_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side of the scoreboard: record the control character the crossing implies
   task automatic set_level(input logic [LW-1:0] lvl, input bit expect_ctl, input logic [DW-1:0] c);
      if (expect_ctl) exp_q.push_back(c);
      rx_level = lvl;
   endtask

   // one received-character strobe; rx_wr checked inside the strobe cycle
   task automatic rx_strobe(input logic [DW-1:0] c, input bit exp_wr, input string req);
      rx_char = c;
      rx_char_vld = 1'b1;
      #1;
      chk(req, rx_wr, exp_wr);
      nclk(1);
      rx_char_vld = 1'b0;
   endtask

   // monitor: take each requested control character and compare with the scoreboard
   always @(negedge clk) begin
      if (!rst_n) ins_ack <= 1'b0;
      else if (ins_ack) ins_ack <= 1'b0;
      else if (ins_req) begin
         ins_seen++;
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2/R3: actual=%0h expected=none (unexpected insertion)", ins_chr);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            if (ins_chr !== e) begin
               bad++;
               $display("FAIL R2/R3: actual=%0h expected=%0h", ins_chr, e);
            end
         end
         ins_ack <= 1'b1;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_ib_en = 1'b1; cfg_oob_mode = 2'b11;
      cfg_hi_thr = 8'd100; cfg_lo_thr = 8'd20; cfg_xon = XON; cfg_xoff = XOFF;
      cfg_tx_dis = 1'b0; cfg_rx_dis = 1'b0; rx_level = 8'd0; rx_char_vld = 1'b0;
      rx_char = '0; tx_q_nempty = 1'b1; tx_busy = 1'b0; cts_n = 1'b0; dsr_n = 1'b0;
      nclk(3);
      rst_n = 1'b1;
      nclk(1);
      // R1 reset state
      chk("R1 status", fc_status, 4'h0);
      chk("R1 ins_req", ins_req, 1'b0);
      chk("R1 rts_n", rts_n, 1'b0);
      chk("R1 dtr_n", dtr_n, 1'b0);
      chk("R1 tx_go", tx_go, 1'b1);

      // R2 crossing exactly at the upper mark
      set_level(8'd100, 1, XOFF);
      nclk(1);
      chk("R2 throttled", fc_status[0], 1'b1);
      chk("R10 pending bit", fc_status[3], 1'b1);
      chk("R4 priority", tx_go, 1'b0);
      chk("R7 rts_n high", rts_n, 1'b1);
      chk("R7 dtr_n high", dtr_n, 1'b1);
      nclk(4);
      chk("R2 single xoff", ins_seen, 1);
      chk("R4 go after ack", tx_go, 1'b1);
      // R3 dead band then the lower mark
      set_level(8'd50, 0, 8'h00);
      nclk(2);
      chk("R3 dead band", fc_status[0], 1'b1);
      set_level(8'd20, 1, XON);
      nclk(1);
      chk("R3 released", fc_status[0], 1'b0);
      chk("R7 rts_n low", rts_n, 1'b0);
      nclk(4);
      chk("R3 single xon", ins_seen, 2);

      // R5 / R6 received control characters
      rx_strobe(XOFF, 1'b0, "R6 xoff consumed");
      chk("R5 paused", fc_status[1], 1'b1);
      chk("R5 go low", tx_go, 1'b0);
      rx_strobe(8'h41, 1'b1, "R6 data written");
      chk("R5 still paused", fc_status[1], 1'b1);
      rx_strobe(XON, 1'b0, "R6 xon consumed");
      chk("R5 resumed", tx_go, 1'b1);

      // R9 receiver disabled
      cfg_rx_dis = 1'b1;
      rx_strobe(XOFF, 1'b0, "R9 rx_wr off");
      chk("R9 xoff ignored", fc_status[1], 1'b0);
      cfg_rx_dis = 1'b0;
      // R9 transmitter disabled keeps pending request
      cfg_tx_dis = 1'b1;
      #1;
      chk("R9 go off", tx_go, 1'b0);
      set_level(8'd120, 1, XOFF);
      nclk(3);
      chk("R9 no req", ins_req, 1'b0);
      chk("R9 kept pending", fc_status[3], 1'b1);
      cfg_tx_dis = 1'b0;
      nclk(4);
      chk("R9 sent later", ins_seen, 3);
      set_level(8'd0, 1, XON);
      nclk(4);

      // R8 modem input with synchronizer latency
      cts_n = 1'b1;
      nclk(2);
      chk("R8 not yet", fc_status[2], 1'b0);
      nclk(1);
      chk("R8 hold", fc_status[2], 1'b1);
      chk("R8 go low", tx_go, 1'b0);
      cts_n = 1'b0;
      nclk(3);
      chk("R8 release", tx_go, 1'b1);
      tx_busy = 1'b1;
      cts_n = 1'b1;
      nclk(5);
      chk("R8 waits boundary", fc_status[2], 1'b0);
      tx_busy = 1'b0;
      nclk(1);
      chk("R8 at boundary", fc_status[2], 1'b1);
      cts_n = 1'b0;
      nclk(4);

      // R7 / R8 only the DTR/DSR pair enabled
      cfg_oob_mode = 2'b10;
      cts_n = 1'b1;
      nclk(4);
      chk("R8 cts ignored", fc_status[2], 1'b0);
      dsr_n = 1'b1;
      nclk(4);
      chk("R8 dsr hold", fc_status[2], 1'b1);
      dsr_n = 1'b0;
      cts_n = 1'b0;
      nclk(4);
      set_level(8'd200, 1, XOFF);
      nclk(1);
      chk("R7 rts disabled", rts_n, 1'b0);
      chk("R7 dtr active", dtr_n, 1'b1);
      nclk(3);
      set_level(8'd5, 1, XON);
      nclk(4);

      // R11 in-band disabled
      cfg_ib_en = 1'b0;
      set_level(8'd100, 0, 8'h00);
      nclk(4);
      chk("R11 no insertion", ins_seen, 6);
      chk("R11 throttled", fc_status[0], 1'b1);
      chk("R11 dtr follows", dtr_n, 1'b1);
      rx_strobe(XOFF, 1'b1, "R11 xoff as data");
      chk("R11 no pause", tx_go, 1'b1);
      set_level(8'd0, 0, 8'h00);
      nclk(2);
      chk("R11 released", dtr_n, 1'b0);

      chk("R2 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule